// File: doc/BRIEF.md
# Centisecond Stopwatch Core

This block keeps stopwatch time from one system clock. A timebase divides the clock into a single-cycle pulse every 10 ms (500,000 cycles of a 50 MHz clock by default). A three-state control machine (idle, running, paused) is driven by two active-low pushbutton inputs: one starts or resumes and one pauses. The active-low reset clears everything. While running, every timebase pulse advances a chain of six cascaded BCD digits laid out as minutes, seconds and centiseconds (MM:SS:CC).

Each digit is a small counter with its own wrap limit. A digit that wraps passes a carry enable to the next higher digit in the same cycle, so several digits can roll over together on one pulse. The six digits are plain 4-bit BCD values held in registers, ready for an external display decoder. The tick period is a parameter, so short periods can be used for test. The limit of the minutes-tens digit is also a parameter, so a full wrap can be reached in fewer ticks.

Top module: `sw_stopwatch_core`

## Requirements
- R1: When `rst_n` is low, all six digits become 0 at once, without waiting for a clock edge, and the control machine returns to idle.
- R2: After reset the timebase counter holds TICK_CYCLES-1 and counts down once per clock. When it reaches zero it reloads, and the pulse is high for exactly the following cycle. Pulses therefore come every TICK_CYCLES cycles.
- R3: In idle, `start_n`=0 moves the machine to running. A low `pause_n` is ignored in idle, and the digits stay at 0.
- R4: In running, `pause_n`=0 moves the machine to paused. A low `start_n` alone is ignored in running.
- R5: In paused, `start_n`=0 resumes running, and this holds even when `pause_n` is low in the same cycle. The digits hold their values while paused.
- R6: The machine keeps its state after a button is released, so a single-cycle press is enough.
- R7: The centisecond ones digit advances by one only on a clock edge where the state is running and the timebase pulse is high. On every other edge all digits stay the same.
- R8: The ones digits and the centisecond tens digit count 0 to 9, and the seconds tens digit counts 0 to 5. A digit at its limit that is enabled returns to 0 and advances the next higher digit on the same edge.
- R9: The minutes tens digit counts 0 to MIN_TENS_LIMIT (default 5). From the top value (59:59.99 by default) the next advance shows 00:00.00.
- R10: Both buttons are active low: a value of 1 is a released button and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (reset button) |
| start_n | input | 1 | Start/resume button, 0 = pressed |
| pause_n | input | 1 | Pause button, 0 = pressed |
| cs_ones | output | 4 | Centiseconds, ones digit (BCD) |
| cs_tens | output | 4 | Centiseconds, tens digit (BCD) |
| sec_ones | output | 4 | Seconds, ones digit (BCD) |
| sec_tens | output | 4 | Seconds, tens digit (BCD 0-5) |
| min_ones | output | 4 | Minutes, ones digit (BCD) |
| min_tens | output | 4 | Minutes, tens digit (BCD 0-MIN_TENS_LIMIT) |

## Verification
The bench builds two copies of the core. The first uses TICK_CYCLES=4 with the default digit limits, so a few tens of thousands of cycles reach carries through the centisecond, second and seconds-tens digits and into minutes, all with the exact tick phase. The second uses TICK_CYCLES=1 and MIN_TENS_LIMIT=0, so a pulse comes on every cycle and the full display wraps after 60,000 ticks. This brings the all-digits rollover back to 00:00.00 within the cycle budget.

// File: rtl/sw_pkg.sv
package sw_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned N_DIGITS = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } run_state_e;

  // Wrap limit of each digit position, least significant first:
  // cc ones, cc tens, ss ones, ss tens, mm ones, mm tens.
  function automatic int unsigned digit_limit(input int unsigned idx,
                                              input int unsigned min_tens_lim);
    case (idx)
      3:       digit_limit = 5;
      5:       digit_limit = min_tens_lim;
      default: digit_limit = 9;
    endcase
  endfunction

endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int unsigned TICK_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= RELOAD;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl
  import sw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_n,
  input  logic       pause_n,
  output run_state_e state,
  output logic       running
);

  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (!start_n) state_d = ST_RUN;
      ST_RUN:   if (!pause_n) state_d = ST_PAUSE;
      ST_PAUSE: if (!start_n) state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign running = (state_q == ST_RUN);

endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int unsigned MAXV = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  output logic [DIGIT_W-1:0] value,
  output logic               carry
);

  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(MAXV);

  logic [DIGIT_W-1:0] val_q;
  logic               at_top;

  assign at_top = (val_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (inc)    val_q <= at_top ? '0 : val_q + 1'b1;
  end

  assign value = val_q;
  assign carry = inc & at_top;

endmodule

// File: rtl/sw_stopwatch_core.sv
module sw_stopwatch_core
  import sw_pkg::*;
#(
  parameter int unsigned TICK_CYCLES    = 500000,
  parameter int unsigned MIN_TENS_LIMIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_n,
  input  logic       pause_n,
  output logic [3:0] cs_ones,
  output logic [3:0] cs_tens,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens
);

  logic                              tick_pulse;
  logic                              run_now;
  run_state_e                        run_state;
  logic [N_DIGITS:0]                 step_en;
  logic [N_DIGITS-1:0][DIGIT_W-1:0]  dig_q;

  sw_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_pulse)
  );

  sw_run_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .pause_n (pause_n),
    .state   (run_state),
    .running (run_now)
  );

  assign step_en[0] = run_now & tick_pulse;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_digit
    localparam int unsigned LIM = digit_limit(i, MIN_TENS_LIMIT);
    sw_digit #(.MAXV(LIM)) u_dig (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (step_en[i]),
      .value (dig_q[i]),
      .carry (step_en[i+1])
    );
  end

  assign cs_ones  = dig_q[0];
  assign cs_tens  = dig_q[1];
  assign sec_ones = dig_q[2];
  assign sec_tens = dig_q[3];
  assign min_ones = dig_q[4];
  assign min_tens = dig_q[5];

endmodule

// File: rtl/sw_stopwatch_chk.sv
module sw_stopwatch_chk
  import sw_pkg::*;
#(
  parameter int unsigned TICK_CYCLES    = 500000,
  parameter int unsigned MIN_TENS_LIMIT = 5
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             start_n,
  input logic                             pause_n,
  input logic                             tick,
  input run_state_e                       state,
  input logic [N_DIGITS-1:0][DIGIT_W-1:0] dg
);

  logic adv;
  logic all_top;
  assign adv = (state == ST_RUN) && tick;
  assign all_top = (dg[0] == 4'd9) && (dg[1] == 4'd9) && (dg[2] == 4'd9) &&
                   (dg[3] == 4'd5) && (dg[4] == 4'd9) &&
                   (dg[5] == DIGIT_W'(MIN_TENS_LIMIT));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (dg == '0);
    end
  end

  if (TICK_CYCLES > 1) begin : g_pulse
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_n) |=> (state == ST_IDLE));

  assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_n) |=> (state == ST_RUN));

  assert_run_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !pause_n) |=> (state == ST_PAUSE));

  assert_pause_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE && !start_n) |=> (state == ST_RUN));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(dg));

  assert_lsd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dg[0] != 4'd9) |=> (dg[0] == 4'($past(dg[0]) + 4'd1)));

  assert_digit_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dg[0] <= 4'd9) && (dg[1] <= 4'd9) && (dg[2] <= 4'd9) &&
    (dg[3] <= 4'd5) && (dg[4] <= 4'd9));

  assert_sec_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dg[0] == 4'd9 && dg[1] == 4'd9)
      |=> (dg[0] == 4'd0 && dg[1] == 4'd0 && dg[2] != $past(dg[2])));

  assert_min_tens_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dg[5] <= DIGIT_W'(MIN_TENS_LIMIT));

  assert_full_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && all_top) |=> (dg == '0));

endmodule

bind sw_stopwatch_core sw_stopwatch_chk #(
  .TICK_CYCLES   (TICK_CYCLES),
  .MIN_TENS_LIMIT(MIN_TENS_LIMIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_n (start_n),
  .pause_n (pause_n),
  .tick    (tick_pulse),
  .state   (run_state),
  .dg      (dig_q)
);

// File: tb/sw_stopwatch_core_tb.sv
// Spec-level reference: tick schedule, run state and elapsed centiseconds.
module sw_ref_model #(
  parameter int unsigned TICK_CYCLES    = 4,
  parameter int unsigned MIN_TENS_LIMIT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_n,
  input  logic        pause_n,
  output int unsigned total,
  output logic [23:0] exp_dig
);
  localparam int unsigned WRAP = (MIN_TENS_LIMIT + 1) * 60000;
  int unsigned since;      // edges since last timebase reload
  logic        pulse;
  int          mode;       // 0 idle, 1 running, 2 paused

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 0; pulse <= 1'b0; mode <= 0; total <= 0;
    end else begin
      if (since == TICK_CYCLES - 1) begin since <= 0; pulse <= 1'b1; end
      else begin since <= since + 1; pulse <= 1'b0; end
      if (mode == 0 && !start_n) mode <= 1;
      else if (mode == 1 && !pause_n) mode <= 2;
      else if (mode == 2 && !start_n) mode <= 1;
      if (mode == 1 && pulse) total <= (total + 1) % WRAP;
    end
  end

  always_comb begin
    int unsigned cc, ss, mm;
    cc = total % 100;
    ss = (total / 100) % 60;
    mm = total / 6000;
    exp_dig = {4'(mm / 10), 4'(mm % 10), 4'(ss / 10), 4'(ss % 10),
               4'(cc / 10), 4'(cc % 10)};
  end
endmodule

module sw_stopwatch_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, pause_n = 1'b1;
  logic w_start_n = 1'b1;
  int   n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  logic [3:0] c1, c10, s1, s10, m1, m10;
  logic [3:0] wc1, wc10, ws1, ws10, wm1, wm10;

  sw_stopwatch_core #(.TICK_CYCLES(4), .MIN_TENS_LIMIT(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pause_n(pause_n),
    .cs_ones(c1), .cs_tens(c10), .sec_ones(s1), .sec_tens(s10),
    .min_ones(m1), .min_tens(m10));

  sw_stopwatch_core #(.TICK_CYCLES(1), .MIN_TENS_LIMIT(0)) u_wrap (
    .clk(clk), .rst_n(rst_n), .start_n(w_start_n), .pause_n(1'b1),
    .cs_ones(wc1), .cs_tens(wc10), .sec_ones(ws1), .sec_tens(ws10),
    .min_ones(wm1), .min_tens(wm10));

  int unsigned tot_a, tot_w;
  logic [23:0] exp_a, exp_w;
  sw_ref_model #(.TICK_CYCLES(4), .MIN_TENS_LIMIT(5)) u_ref_a (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pause_n(pause_n),
    .total(tot_a), .exp_dig(exp_a));
  sw_ref_model #(.TICK_CYCLES(1), .MIN_TENS_LIMIT(0)) u_ref_w (
    .clk(clk), .rst_n(rst_n), .start_n(w_start_n), .pause_n(1'b1),
    .total(tot_w), .exp_dig(exp_w));

  wire [23:0] got_a = {m10, m1, s10, s1, c10, c1};
  wire [23:0] got_w = {wm10, wm1, ws10, ws1, wc10, wc1};

  task automatic check(input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // {start_n, pause_n, cycles to hold}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd12},    // R3: pause in idle ignored
    {1'b1, 1'b1, 16'd20},    // R10: released buttons do nothing
    {1'b0, 1'b1, 16'd1},     // R3: start from idle
    {1'b1, 1'b1, 16'd40},    // R6: keeps running after release
    {1'b0, 1'b1, 16'd8},     // R4: start while running ignored
    {1'b1, 1'b0, 16'd1},     // R4: pause
    {1'b1, 1'b1, 16'd30},    // R5: frozen while paused
    {1'b0, 1'b0, 16'd1},     // R5: start wins in paused
    {1'b1, 1'b1, 16'd400},   // R8: carry into seconds
    {1'b1, 1'b0, 16'd2},
    {1'b1, 1'b1, 16'd10},
    {1'b0, 1'b1, 16'd1},
    {1'b1, 1'b1, 16'd4000},  // R8: seconds tens
    {1'b1, 1'b1, 16'd24000}  // R8: into minutes
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", got_a, 24'h0);
    rst_n = 1'b1;

    // R2/R7: exact tick phase right after reset, checked every cycle
    @(negedge clk); start_n = 1'b0;
    @(negedge clk); start_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R2 R7 tick phase", got_a, exp_a);
    end
    check("R2 three ticks counted", got_a, 24'h000003);

    // restart for the table walk
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      start_n = VEC[v][17];
      pause_n = VEC[v][16];
      repeat (int'(VEC[v][15:0])) @(negedge clk);
      check($sformatf("R7 R8 table step %0d", v), got_a, exp_a);
    end
    start_n = 1'b1; pause_n = 1'b1;
    check("R8 minutes reached", {4'd0, got_a[19:16]} >= 8'd1 ? 24'h1 : 24'h0,
          24'h1);

    // R1: asynchronous clear in the middle of a cycle
    #2 rst_n = 1'b0;
    #1 check("R1 async clear", got_a, 24'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 idle after reset", got_a, 24'h0);

    // R9: full wrap on the short-limit copy
    w_start_n = 1'b0;
    @(negedge clk); w_start_n = 1'b1;
    while (tot_w != 59999) @(negedge clk);
    check("R9 top value 09:59.99", got_w, 24'h095999);
    @(negedge clk);
    check("R9 wrap to 00:00.00", got_w, 24'h000000);
    @(negedge clk);
    check("R9 counts on after wrap", got_w, exp_w);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule